// File: doc/BRIEF.md
# Infrared Pulse-Interval Classifier

This block measures the time between successive level changes of an infrared remote input, which arrives already synchronised to the system clock. A 6-bit interval counter advances once per sampling tick. At every edge the counter's value is classified and then the counter restarts from zero. Each classified interval yields a one-cycle event that carries three things: whether it was a leader, the data bit's logic level, and whether the interval counts as long data or short data.

Two timing scales are selectable. In the half scale a nominal 0 is 4 ticks and a nominal 1 is 8 ticks. The full scale doubles every data threshold; there a 0 is 8 ticks, a 1 is 16 ticks and a leader is 32 ticks. The leader threshold is programmable in steps of 4 ticks. A sticky status flag records that a leader was seen.

If 63 ticks pass with no edge, the block treats this as a trailer. It then stops counting and ignores sampling ticks until the next edge re-arms it.

The controller has two states. `ST_IDLE` means ticks are gated off and the block is waiting for an edge. `ST_COUNT` means intervals are being measured. Its transitions are:
- `ARM`: an edge in `ST_IDLE` moves to `ST_COUNT` and zeroes the counter.
- `MEASURE`: an edge in `ST_COUNT` classifies the interval, zeroes the counter and stays in `ST_COUNT`.
- `TICK`: a tick with no edge in `ST_COUNT` increments the counter.
- `TRAIL`: a tick that brings the counter to 63 moves to `ST_IDLE`.

Top module: `ir_interval_classifier`

## Requirements
- R1: After a synchronous reset, `ev_valid`, `long_flag`, `trailer` and `ts_en` are all 0, and the reference level for edge detection is 0.
- R2: An edge in the gated (idle) state produces no event. It raises `ts_en` and restarts the count at 0. `ev_valid` is never asserted unless `ts_en` was 1 in the cycle before.
- R3: In half scale (`mode_full`=0), an interval of fewer than 6 ticks reports `ev_bit`=0, and an interval of 6 or more ticks reports `ev_bit`=1.
- R4: In full scale (`mode_full`=1), an interval of fewer than 12 ticks reports `ev_bit`=0, and an interval of 12 or more ticks reports `ev_bit`=1.
- R5: In half scale, an interval of 10 or more ticks sets `ev_long` and an interval below 2 ticks sets `ev_short`. The two are never set together.
- R6: In full scale, an interval of 20 or more ticks sets `ev_long` and an interval below 4 ticks sets `ev_short`.
- R7: When `leader_cfg` is nonzero and the interval is at least `leader_cfg`×4 ticks, the event reports `ev_leader`=1 with `ev_bit`, `ev_long` and `ev_short` all 0. A `leader_cfg` of 0 disables leader detection.
- R8: A leader event sets `long_flag`, and the flag holds until `long_clr` is 1 at a clock edge. If a leader and a clear arrive in the same cycle, the flag is set.
- R9: When 63 ticks pass without an edge, `trailer` pulses for one cycle and `ts_en` falls to 0. Ticks received while gated do not advance the count.
- R10: The event appears on the clock edge after the one that sampled the level change, and lasts one cycle. A tick that arrives in the same cycle as an edge is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ts_tick | input | 1 | Sampling tick enable, one cycle wide |
| sig_in | input | 1 | Synchronised remote input level |
| mode_full | input | 1 | 0: half-scale thresholds, 1: full-scale thresholds |
| leader_cfg | input | 4 | Leader threshold in units of 4 ticks; 0 disables leader detection |
| long_clr | input | 1 | Write-one-to-clear strobe for `long_flag` |
| ev_valid | output | 1 | One-cycle pulse for each classified interval |
| ev_leader | output | 1 | Interval classified as a leader |
| ev_bit | output | 1 | Decoded data bit level |
| ev_long | output | 1 | Interval classified as long data |
| ev_short | output | 1 | Interval classified as short data |
| long_flag | output | 1 | Sticky flag, set by a leader |
| trailer | output | 1 | One-cycle pulse when the count saturates with no edge |
| ts_en | output | 1 | Tick gate: 1 while counting |

## Verification
The bench uses the default parameters: a 6-bit counter, half-scale thresholds of 6, 10 and 2 ticks, and a leader step of 4 ticks. With these, the 63-tick trailer is reached within a few hundred cycles.

Every threshold is tested on both sides of its boundary in both scales. The table uses leader settings of 6 and 8, which give the nominal 24- and 32-tick leaders. A directed test sets the leader setting to 0 so that a 40-tick interval falls through to data classification.

// File: rtl/ir_cls_pkg.sv
package ir_cls_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic leader;
        logic bitv;
        logic is_long;
        logic is_short;
    } ev_class_t;
endpackage

// File: rtl/ir_edge_detect.sv
module ir_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic edge_hit
);
    logic ref_q;

    always_ff @(posedge clk) begin
        if (rst) ref_q <= 1'b0;
        else     ref_q <= sig_in;
    end

    assign edge_hit = sig_in ^ ref_q;
endmodule

// File: rtl/ir_interval_ctl.sv
module ir_interval_ctl
    import ir_cls_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_hit,
    input  logic             ts_tick,
    output logic [CNT_W-1:0] cnt,
    output logic             measure,
    output logic             trailer,
    output logic             ts_en
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_MAX - 1'b1;

    ctl_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             trail_q, trail_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            trail_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            trail_q <= trail_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        trail_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (edge_hit) begin          // ARM
                    state_d = ST_COUNT;
                    cnt_d   = '0;
                end
            end
            ST_COUNT: begin
                if (edge_hit) begin          // MEASURE
                    cnt_d = '0;
                end else if (ts_tick) begin
                    if (cnt_q == CNT_LAST) begin  // TRAIL
                        cnt_d   = CNT_MAX;
                        state_d = ST_IDLE;
                        trail_d = 1'b1;
                    end else begin           // TICK
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign cnt     = cnt_q;
    assign measure = edge_hit && (state_q == ST_COUNT);
    assign trailer = trail_q;
    assign ts_en   = (state_q == ST_COUNT);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COUNT) |-> (cnt_q != CNT_MAX)); // R9
    AST_TRAILER_GATES: assert property (@(posedge clk) disable iff (rst)
        trail_q |-> (state_q == ST_IDLE)); // R9
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) && !edge_hit |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/ir_interval_judge.sv
module ir_interval_judge
    import ir_cls_pkg::*;
#(
    parameter int CNT_W      = 6,
    parameter int CFG_W      = 4,
    parameter int BIT_THR_H  = 6,
    parameter int LONG_THR_H = 10,
    parameter int SHRT_THR_H = 2,
    parameter int LEAD_STEP  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             measure,
    input  logic [CNT_W-1:0] cnt,
    input  logic             mode_full,
    input  logic [CFG_W-1:0] leader_cfg,
    input  logic             long_clr,
    output logic             ev_valid,
    output ev_class_t        ev_cls,
    output logic             long_flag
);
    localparam int TW = CNT_W + CFG_W + 3;

    logic [TW-1:0] ival, thr_bit, thr_long, thr_shrt, thr_lead;
    ev_class_t     cls_d, cls_q;
    logic          valid_q, flag_q, is_lead;

    assign ival     = TW'(cnt);
    assign thr_bit  = mode_full ? TW'(2 * BIT_THR_H)  : TW'(BIT_THR_H);
    assign thr_long = mode_full ? TW'(2 * LONG_THR_H) : TW'(LONG_THR_H);
    assign thr_shrt = mode_full ? TW'(2 * SHRT_THR_H) : TW'(SHRT_THR_H);
    assign thr_lead = TW'(leader_cfg) * TW'(LEAD_STEP);
    assign is_lead  = (leader_cfg != '0) && (ival >= thr_lead);

    always_comb begin
        cls_d = '0;
        if (is_lead) begin
            cls_d.leader = 1'b1;
        end else begin
            cls_d.bitv     = (ival >= thr_bit);
            cls_d.is_long  = (ival >= thr_long);
            cls_d.is_short = (ival <  thr_shrt);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            cls_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            valid_q <= measure;
            cls_q   <= measure ? cls_d : '0;
            if (measure && is_lead) flag_q <= 1'b1;
            else if (long_clr)      flag_q <= 1'b0;
        end
    end

    assign ev_valid  = valid_q;
    assign ev_cls    = cls_q;
    assign long_flag = flag_q;

    AST_LEADER_ALONE: assert property (@(posedge clk) disable iff (rst)
        valid_q && cls_q.leader |-> !cls_q.bitv && !cls_q.is_long && !cls_q.is_short); // R7
    AST_LONG_SHORT_EXCL: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> !(cls_q.is_long && cls_q.is_short)); // R5
    AST_LONG_IS_ONE: assert property (@(posedge clk) disable iff (rst)
        valid_q && cls_q.is_long |-> cls_q.bitv); // R3
    AST_SHORT_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
        valid_q && cls_q.is_short |-> !cls_q.bitv); // R4
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        flag_q && !long_clr |=> flag_q); // R8
    AST_FLAG_FROM_LEADER: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> valid_q && cls_q.leader); // R8
endmodule

// File: rtl/ir_interval_classifier.sv
module ir_interval_classifier
    import ir_cls_pkg::*;
#(
    parameter int CNT_W      = 6,
    parameter int CFG_W      = 4,
    parameter int BIT_THR_H  = 6,
    parameter int LONG_THR_H = 10,
    parameter int SHRT_THR_H = 2,
    parameter int LEAD_STEP  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ts_tick,
    input  logic             sig_in,
    input  logic             mode_full,
    input  logic [CFG_W-1:0] leader_cfg,
    input  logic             long_clr,
    output logic             ev_valid,
    output logic             ev_leader,
    output logic             ev_bit,
    output logic             ev_long,
    output logic             ev_short,
    output logic             long_flag,
    output logic             trailer,
    output logic             ts_en
);
    logic             edge_hit, measure;
    logic [CNT_W-1:0] cnt;
    ev_class_t        cls;

    ir_edge_detect u_edge (
        .clk      (clk),
        .rst      (rst),
        .sig_in   (sig_in),
        .edge_hit (edge_hit)
    );

    ir_interval_ctl #(.CNT_W(CNT_W)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .edge_hit (edge_hit),
        .ts_tick  (ts_tick),
        .cnt      (cnt),
        .measure  (measure),
        .trailer  (trailer),
        .ts_en    (ts_en)
    );

    ir_interval_judge #(
        .CNT_W      (CNT_W),
        .CFG_W      (CFG_W),
        .BIT_THR_H  (BIT_THR_H),
        .LONG_THR_H (LONG_THR_H),
        .SHRT_THR_H (SHRT_THR_H),
        .LEAD_STEP  (LEAD_STEP)
    ) u_judge (
        .clk        (clk),
        .rst        (rst),
        .measure    (measure),
        .cnt        (cnt),
        .mode_full  (mode_full),
        .leader_cfg (leader_cfg),
        .long_clr   (long_clr),
        .ev_valid   (ev_valid),
        .ev_cls     (cls),
        .long_flag  (long_flag)
    );

    assign ev_leader = cls.leader;
    assign ev_bit    = cls.bitv;
    assign ev_long   = cls.is_long;
    assign ev_short  = cls.is_short;

    AST_EVENT_NEEDS_COUNT: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> $past(ts_en)); // R2
    AST_TRAILER_PULSE: assert property (@(posedge clk) disable iff (rst)
        trailer |=> !trailer); // R9
endmodule

// File: tb/ir_interval_classifier_tb.sv
module ir_interval_classifier_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ts_tick = 1'b0;
    logic       sig_in = 1'b0;
    logic       mode_full = 1'b0;
    logic [3:0] leader_cfg = 4'd6;
    logic       long_clr = 1'b0;
    logic       ev_valid, ev_leader, ev_bit, ev_long, ev_short;
    logic       long_flag, trailer, ts_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ir_interval_classifier u_dut (
        .clk(clk), .rst(rst), .ts_tick(ts_tick), .sig_in(sig_in),
        .mode_full(mode_full), .leader_cfg(leader_cfg), .long_clr(long_clr),
        .ev_valid(ev_valid), .ev_leader(ev_leader), .ev_bit(ev_bit),
        .ev_long(ev_long), .ev_short(ev_short), .long_flag(long_flag),
        .trailer(trailer), .ts_en(ts_en)
    );

    // vector: [15] mode_full, [14:11] leader_cfg, [10:5] ticks,
    //         [3:0] expected {leader, bit, long, short}
    localparam int NV = 20;
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 4'd6,  6'd1, 1'b0, 4'b0001},  // R5 short, R3 zero
        {1'b0, 4'd6,  6'd2, 1'b0, 4'b0000},  // R5 short edge
        {1'b0, 4'd6,  6'd4, 1'b0, 4'b0000},  // R3 nominal 0
        {1'b0, 4'd6,  6'd5, 1'b0, 4'b0000},  // R3
        {1'b0, 4'd6,  6'd6, 1'b0, 4'b0100},  // R3 one
        {1'b0, 4'd6,  6'd8, 1'b0, 4'b0100},  // R3 nominal 1
        {1'b0, 4'd6,  6'd9, 1'b0, 4'b0100},  // R5
        {1'b0, 4'd6, 6'd10, 1'b0, 4'b0110},  // R5 long
        {1'b0, 4'd6, 6'd23, 1'b0, 4'b0110},  // R7 below leader
        {1'b0, 4'd6, 6'd24, 1'b0, 4'b1000},  // R7 leader
        {1'b1, 4'd8,  6'd3, 1'b0, 4'b0001},  // R6 short
        {1'b1, 4'd8,  6'd4, 1'b0, 4'b0000},  // R6
        {1'b1, 4'd8,  6'd8, 1'b0, 4'b0000},  // R4 nominal 0
        {1'b1, 4'd8, 6'd11, 1'b0, 4'b0000},  // R4
        {1'b1, 4'd8, 6'd12, 1'b0, 4'b0100},  // R4 one
        {1'b1, 4'd8, 6'd16, 1'b0, 4'b0100},  // R4 nominal 1
        {1'b1, 4'd8, 6'd19, 1'b0, 4'b0100},  // R6
        {1'b1, 4'd8, 6'd20, 1'b0, 4'b0110},  // R6 long
        {1'b1, 4'd8, 6'd31, 1'b0, 4'b0110},  // R7 below leader
        {1'b1, 4'd8, 6'd32, 1'b0, 4'b1000}   // R7 leader
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // n ticks, then a level change (optionally with tick/clear in that cycle);
    // returns at the negedge after the edge-sampling posedge.
    task automatic interval(input int n, input bit tick_at_edge, input bit clr_at_edge);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ts_tick = 1'b1;
        end
        @(negedge clk);
        ts_tick  = tick_at_edge;
        long_clr = clr_at_edge;
        sig_in   = ~sig_in;
        @(negedge clk);
        ts_tick  = 1'b0;
        long_clr = 1'b0;
    endtask

    function automatic int evbits();
        return {ev_valid, ev_leader, ev_bit, ev_long, ev_short};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk({ev_valid, long_flag, trailer, ts_en} == 4'b0, "R1 reset outputs",
            {ev_valid, long_flag, trailer, ts_en}, 0);
        // R2 first edge arms, no event
        interval(0, 1'b0, 1'b0);
        chk(ev_valid == 1'b0 && ts_en == 1'b1, "R2 arm without event",
            {ev_valid, ts_en}, 1);

        for (int k = 0; k < NV; k++) begin
            mode_full  = VEC[k][15];
            leader_cfg = VEC[k][14:11];
            interval(int'(VEC[k][10:5]), 1'b0, 1'b0);
            chk(evbits() == {1'b1, VEC[k][3:0]}, $sformatf("R3/R4/R5/R6/R7 vector %0d", k),
                evbits(), {1'b1, VEC[k][3:0]});
        end

        // R8 flag set by leader, held, cleared, set wins over clear
        chk(long_flag == 1'b1, "R8 flag after leader", long_flag, 1);
        @(negedge clk);
        chk(ev_valid == 1'b0, "R10 one-cycle event", ev_valid, 0);
        chk(long_flag == 1'b1, "R8 flag held", long_flag, 1);
        long_clr = 1'b1;
        @(negedge clk);
        long_clr = 1'b0;
        chk(long_flag == 1'b0, "R8 flag cleared", long_flag, 0);
        mode_full = 1'b0; leader_cfg = 4'd6;
        interval(24, 1'b0, 1'b1);
        chk(long_flag == 1'b1 && ev_leader == 1'b1, "R8 set wins over clear",
            {long_flag, ev_leader}, 3);

        // R7 leader disabled with setting 0
        mode_full = 1'b1; leader_cfg = 4'd0;
        interval(40, 1'b0, 1'b0);
        chk(evbits() == 5'b10110, "R7 leader disabled", evbits(), 5'b10110);

        // R10 tick in edge cycle not counted: 1 tick -> short in half scale
        mode_full = 1'b0; leader_cfg = 4'd6;
        interval(5, 1'b1, 1'b0);
        interval(1, 1'b0, 1'b0);
        chk(evbits() == 5'b10001, "R10 tick at edge ignored", evbits(), 5'b10001);

        // R9 trailer after 63 ticks
        for (int i = 0; i < 63; i++) begin
            @(negedge clk) ts_tick = 1'b1;
        end
        @(negedge clk) ts_tick = 1'b0;
        chk(trailer == 1'b1 && ts_en == 1'b0, "R9 trailer pulse",
            {trailer, ts_en}, 2);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk) ts_tick = 1'b1;
        end
        @(negedge clk) ts_tick = 1'b0;
        chk(trailer == 1'b0, "R9 trailer one cycle", trailer, 0);
        interval(0, 1'b0, 1'b0);
        chk(ev_valid == 1'b0 && ts_en == 1'b1, "R2 rearm after trailer",
            {ev_valid, ts_en}, 1);
        interval(3, 1'b0, 1'b0);
        chk(evbits() == 5'b10000, "R9 gated ticks not counted", evbits(), 5'b10000);

        // R1 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        sig_in = 1'b0;
        @(negedge clk);
        chk({ev_valid, long_flag, trailer, ts_en} == 4'b0, "R1 reset clears",
            {ev_valid, long_flag, trailer, ts_en}, 0);

        finish_run();
    end
endmodule